// File: doc/BRIEF.md
# Tag-Scheduled Multi-Tap Pixel Filter Datapath

This block is the filtering engine of an image scaling and enhancement path. It keeps a short history of the most recent pixels and forms a weighted sum of them, with signed weights held in a bank of wide special registers. Three multiplier lanes work side by side. A filter with more taps than lanes is spread over several multiply rounds, and the lanes that have no tap in the last round are given a zero weight. After the multiply rounds, an adder stage accumulates the lane products. A shifter then scales the sum by one of four selectable amounts, and a clipper folds the scaled value into an unsigned 8-bit pixel.

Each pipeline register between the arithmetic units carries a 5-bit tag. The tag holds a valid flag, the 2-bit channel of the pixel that started the operation, and the 2-bit shifter mode chosen for it. A stage acts on a value only when the tag of its input register is valid. If nothing new arrives, the stage drops its own valid flag. The tap count and the shifter mode are sampled once per pixel, when the pixel is accepted. The register bank is written through a simple write port.

Top module: `fir_tag_dp`

## Requirements
- R1: During and straight after reset, out_valid, out_pix and out_tag are all zero and in_ready is 1. The pixel history is all zero.
- R2: Each accepted pixel enters the history as h[0], and older pixels move one place down. Weight k is the signed low 16 bits of special register k. The result is clip(shift(sum over k < T of w[k]*h[k])).
- R3: The number of multiply rounds is R = ceil(T/3). A pixel accepted at a clock edge blocks the next acceptance until R edges later, so with T <= 3 a pixel can be accepted on every cycle.
- R4: out_valid is high for exactly one cycle, R+3 clock edges after the edge that accepted the pixel. Results leave in acceptance order.
- R5: Lanes whose tap index k is at or above T get a zero weight, so special registers T..5 have no effect on the result.
- R6: The shift mode is held in cfg_shmode. Mode 0 is an arithmetic right shift by 8, mode 1 by 16 and mode 2 by 24. Mode 3 shifts right by the low 6 bits of special register 15.
- R7: A negative shifted value gives out_pix 0, and a value above 255 gives out_pix 255.
- R8: While out_valid is high, out_tag is {1, channel[1:0], mode[1:0]}. Bit 4 is the valid flag, bits 3:2 are the in_ch of the pixel and bits 1:0 are its shift mode.
- R9: While out_valid is low, out_pix and out_tag[3:0] keep their last values and out_tag[4] is 0.
- R10: cfg_taps 0 is used as 1 tap, and values above 6 are used as 6 taps.
- R11: cfg_taps and cfg_shmode are sampled only at the edge that accepts a pixel. Later changes do not alter operations already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Special register write enable |
| reg_addr | input | 4 | Special register index |
| reg_wdata | input | 48 | Special register write data |
| cfg_taps | input | 3 | Tap count for the next accepted pixel |
| cfg_shmode | input | 2 | Shifter mode for the next accepted pixel |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be accepted at the next edge |
| in_pix | input | 8 | Unsigned input pixel |
| in_ch | input | 2 | Channel identifier carried in the tag |
| out_valid | output | 1 | Filtered pixel present |
| out_pix | output | 8 | Filtered, clipped pixel |
| out_tag | output | 5 | Tag of the result: valid, channel, mode |

## Verification
The bench targets tap counts that are not multiples of three, where stale weights in registers 4 and 5 would change the sum if the idle lanes were not given zero. It also targets the transition from back-to-back acceptance at three taps to one pixel every two cycles at four to six taps. A wrong stall rule there shows up as a ready mismatch or as overlapping rounds with corrupted sums.

Large positive and negative sums are driven through every shifter mode, including the register-controlled amount, so a wrong shift or a missing saturation shows up in out_pix. The configuration is changed while an operation is still in flight, and the tap-count clamps at 0 and 7 are exercised. A design that re-reads the configuration late, or that drops or reorders tags, gives a wrong value, tag or latency.

// File: rtl/fir_dp_pkg.sv
package fir_dp_pkg;

    typedef enum logic [1:0] {
        SH_BY8   = 2'd0,
        SH_BY16  = 2'd1,
        SH_BY24  = 2'd2,
        SH_BYREG = 2'd3
    } shmode_e;

    // 5-bit tag: valid in bit 4, channel in bits 3:2, mode in bits 1:0
    typedef struct packed {
        logic       valid;
        logic [1:0] ch;
        logic [1:0] mode;
    } tag_t;

endpackage

// File: rtl/fir_regbank.sv
module fir_regbank #(
    parameter int NREG     = 16,
    parameter int RW       = 48,
    parameter int MAX_TAPS = 6,
    parameter int CW       = 16,
    parameter int SAW      = 6,
    localparam int AW      = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [RW-1:0]                  wdata,
    output logic [MAX_TAPS-1:0][CW-1:0]    coef,
    output logic [SAW-1:0]                 shamt
);

    logic [NREG-1:0][RW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar k = 0; k < MAX_TAPS; k++) begin : g_coef
        assign coef[k] = mem_q[k][CW-1:0];
    end

    // shift amount for the register-controlled mode lives in the top register
    assign shamt = mem_q[NREG-1][SAW-1:0];

endmodule

// File: rtl/fir_mul_lanes.sv
module fir_mul_lanes #(
    parameter int LANES    = 3,
    parameter int PW       = 8,
    parameter int CW       = 16,
    parameter int MAX_TAPS = 6,
    parameter int TAPW     = 3,
    parameter int RNDW     = 2,
    localparam int PRODW   = PW + 1 + CW,
    localparam int IW      = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1
) (
    input  logic [MAX_TAPS-1:0][PW-1:0]  win,
    input  logic [MAX_TAPS-1:0][CW-1:0]  coef,
    input  logic [RNDW-1:0]              rnd,
    input  logic [TAPW-1:0]              taps,
    output logic [LANES-1:0][PRODW-1:0]  prod
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic signed [PW:0]       px;
        logic signed [CW-1:0]     cf;
        logic signed [PRODW-1:0]  p_l;
        int unsigned              k;

        always_comb begin
            k  = int'(rnd) * LANES + j;
            px = '0;
            cf = '0;
            // lanes beyond the tap count see a zero weight
            if (k < MAX_TAPS && k < int'(taps)) begin
                px = {1'b0, win[IW'(k)]};
                cf = coef[IW'(k)];
            end
            p_l = PRODW'(px) * PRODW'(cf);
        end

        assign prod[j] = p_l;
    end

endmodule

// File: rtl/fir_shift.sv
module fir_shift #(
    parameter int RW  = 48,
    parameter int SAW = 6
) (
    input  logic signed [RW-1:0] din,
    input  logic [1:0]           mode,
    input  logic [SAW-1:0]       amt,
    output logic signed [RW-1:0] dout
);
    import fir_dp_pkg::*;

    always_comb begin
        case (shmode_e'(mode))
            SH_BY8:   dout = din >>> 8;
            SH_BY16:  dout = din >>> 16;
            SH_BY24:  dout = din >>> 24;
            default:  dout = din >>> amt;
        endcase
    end

endmodule

// File: rtl/fir_clip.sv
module fir_clip #(
    parameter int RW = 48,
    parameter int PW = 8
) (
    input  logic signed [RW-1:0] din,
    output logic [PW-1:0]        dout
);

    localparam logic signed [RW-1:0] PMAX = RW'((1 << PW) - 1);

    always_comb begin
        if (din < 0) begin
            dout = '0;
        end else if (din > PMAX) begin
            dout = '1;
        end else begin
            dout = din[PW-1:0];
        end
    end

endmodule

// File: rtl/fir_tag_dp.sv
module fir_tag_dp #(
    parameter int NREG     = 16,
    parameter int RW       = 48,
    parameter int PW       = 8,
    parameter int CW       = 16,
    parameter int LANES    = 3,
    parameter int MAX_TAPS = 6,
    localparam int AW      = $clog2(NREG),
    localparam int TAPW    = $clog2(MAX_TAPS + 1),
    localparam int MAXR    = (MAX_TAPS + LANES - 1) / LANES,
    localparam int RNDW    = $clog2(MAXR + 1),
    localparam int PRODW   = PW + 1 + CW,
    localparam int SAW     = $clog2(RW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    input  logic [TAPW-1:0] cfg_taps,
    input  logic [1:0]      cfg_shmode,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PW-1:0]   in_pix,
    input  logic [1:0]      in_ch,
    output logic            out_valid,
    output logic [PW-1:0]   out_pix,
    output logic [4:0]      out_tag
);
    import fir_dp_pkg::*;

    typedef enum logic {S_IDLE = 1'b0, S_ISSUE = 1'b1} st_e;

    typedef struct packed {
        st_e                             st;
        logic [RNDW-1:0]                 rnd;
        logic [RNDW-1:0]                 nrnd;
        logic [TAPW-1:0]                 taps;
        logic [1:0]                      mode;
        logic [1:0]                      ch;
        logic [MAX_TAPS-1:0][PW-1:0]     win;
        logic [LANES-1:0][PRODW-1:0]     prod;
        tag_t                            prod_tag;
        logic                            prod_first;
        logic                            prod_last;
        logic [RW-1:0]                   acc;
        tag_t                            acc_tag;
        logic [RW-1:0]                   sh;
        tag_t                            sh_tag;
        logic [PW-1:0]                   opix;
        tag_t                            otag;
    } dp_t;

    dp_t d, q;

    logic [MAX_TAPS-1:0][CW-1:0]  coef;
    logic [SAW-1:0]               shamt;
    logic [LANES-1:0][PRODW-1:0]  lane_prod;
    logic signed [RW-1:0]         shifted;
    logic [PW-1:0]                clipped;
    logic                         ready;
    logic                         take;
    logic [TAPW-1:0]              taps_eff;
    logic signed [RW-1:0]         lane_sum;
    logic                         acc_vld;
    logic                         sh_vld;

    function automatic logic [TAPW-1:0] clamp_taps(logic [TAPW-1:0] t);
        if (t == '0) begin
            return TAPW'(1);
        end else if (int'(t) > MAX_TAPS) begin
            return TAPW'(MAX_TAPS);
        end
        return t;
    endfunction

    function automatic logic [RNDW-1:0] rounds_of(logic [TAPW-1:0] t);
        return RNDW'((int'(t) + LANES - 1) / LANES);
    endfunction

    fir_regbank #(
        .NREG(NREG), .RW(RW), .MAX_TAPS(MAX_TAPS), .CW(CW), .SAW(SAW)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .coef  (coef),
        .shamt (shamt)
    );

    fir_mul_lanes #(
        .LANES(LANES), .PW(PW), .CW(CW), .MAX_TAPS(MAX_TAPS),
        .TAPW(TAPW), .RNDW(RNDW)
    ) u_mul (
        .win  (q.win),
        .coef (coef),
        .rnd  (q.rnd),
        .taps (q.taps),
        .prod (lane_prod)
    );

    fir_shift #(.RW(RW), .SAW(SAW)) u_shift (
        .din  (q.acc),
        .mode (q.acc_tag.mode),
        .amt  (shamt),
        .dout (shifted)
    );

    fir_clip #(.RW(RW), .PW(PW)) u_clip (
        .din  (q.sh),
        .dout (clipped)
    );

    always_comb begin
        d        = q;
        taps_eff = clamp_taps(cfg_taps);
        ready    = (q.st == S_IDLE) || (q.rnd + 1'b1 == q.nrnd);
        take     = in_valid && ready;

        // multiply issue: one round of lane products per cycle
        d.prod_tag.valid = 1'b0;
        if (q.st == S_ISSUE) begin
            d.prod       = lane_prod;
            d.prod_tag   = '{valid: 1'b1, ch: q.ch, mode: q.mode};
            d.prod_first = (q.rnd == '0);
            d.prod_last  = (q.rnd + 1'b1 == q.nrnd);
            d.rnd        = q.rnd + 1'b1;
            if (q.rnd + 1'b1 == q.nrnd) begin
                d.st = S_IDLE;
            end
        end

        // accept a new pixel: shift history and latch configuration
        if (take) begin
            d.win[0] = in_pix;
            for (int i = 1; i < MAX_TAPS; i++) begin
                d.win[i] = q.win[i-1];
            end
            d.st   = S_ISSUE;
            d.rnd  = '0;
            d.taps = taps_eff;
            d.nrnd = rounds_of(taps_eff);
            d.mode = cfg_shmode;
            d.ch   = in_ch;
        end

        // adder: consumes a round of products only when tagged valid
        lane_sum = '0;
        for (int j = 0; j < LANES; j++) begin
            lane_sum = lane_sum + RW'(signed'(q.prod[j]));
        end
        d.acc_tag.valid = 1'b0;
        if (q.prod_tag.valid) begin
            d.acc           = (q.prod_first ? RW'(0) : q.acc) + lane_sum;
            d.acc_tag       = q.prod_tag;
            d.acc_tag.valid = q.prod_last;
        end

        // shifter stage
        d.sh_tag.valid = 1'b0;
        if (q.acc_tag.valid) begin
            d.sh     = shifted;
            d.sh_tag = q.acc_tag;
        end

        // clipper stage and output register
        d.otag.valid = 1'b0;
        if (q.sh_tag.valid) begin
            d.opix = clipped;
            d.otag = q.sh_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = ready;
    assign out_valid = q.otag.valid;
    assign out_pix   = q.opix;
    assign out_tag   = q.otag;
    assign acc_vld   = q.acc_tag.valid;
    assign sh_vld    = q.sh_tag.valid;

endmodule

// File: rtl/fir_tag_dp_chk.sv
module fir_tag_dp_chk #(
    parameter int TAPW  = 3,
    parameter int LANES = 3,
    parameter int PW    = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [TAPW-1:0] cfg_taps,
    input logic            out_valid,
    input logic [PW-1:0]   out_pix,
    input logic [4:0]      out_tag,
    input logic            acc_vld,
    input logic            sh_vld
);

    // R3: more taps than lanes needs a second round, so ready drops
    p_two_rounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && int'(cfg_taps) > LANES) |=> !in_ready);

    // R3: a single round lets the next pixel in at once
    p_one_round_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && int'(cfg_taps) <= LANES) |=> in_ready);

    // R9: held output between results
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_pix) && $stable(out_tag[3:0])));

    // R4: a result comes only from a valid shifter stage
    p_out_from_sh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sh_vld));

    // R4: the shifter stage loads only from a completed sum
    p_sh_from_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_vld |-> $past(acc_vld));

endmodule

bind fir_tag_dp fir_tag_dp_chk #(.TAPW(TAPW), .LANES(LANES), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cfg_taps  (cfg_taps),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .out_tag   (out_tag),
    .acc_vld   (acc_vld),
    .sh_vld    (sh_vld)
);

// File: tb/sim_fir_tag_dp.sv
module sim_fir_tag_dp;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [47:0] reg_wdata = '0;
    logic [2:0]  cfg_taps = 3'd6;
    logic [1:0]  cfg_shmode = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_pix = '0;
    logic [1:0]  in_ch = '0;
    logic        out_valid;
    logic [7:0]  out_pix;
    logic [4:0]  out_tag;

    fir_tag_dp u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg_taps(cfg_taps), .cfg_shmode(cfg_shmode),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_ch(in_ch),
        .out_valid(out_valid), .out_pix(out_pix), .out_tag(out_tag)
    );

    always #(CLK_P/2) clk = ~clk;

    int     cyc = 0;
    int     n_tests = 0;
    int     n_fail = 0;
    longint regm [16];
    int     hist [6];
    int     e_pix [$];
    int     e_tag [$];
    int     e_cyc [$];
    int     last_acc = -100;
    int     last_r = 1;
    int     last_pix = 0;
    int     last_tag = 0;
    bit     acc_next = 1'b0;
    bit     started = 1'b0;
    bit     finished = 1'b0;
    string  req = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string r, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
        end
    endtask

    function automatic int clamp_t(int t);
        if (t == 0) return 1;
        if (t > 6) return 6;
        return t;
    endfunction

    function automatic longint weight(int k);
        longint c;
        c = regm[k] & 64'hFFFF;
        if (c >= 32768) c = c - 65536;
        return c;
    endfunction

    // monitor and reference model, a quarter period before each rising edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (started) begin
            bit exp_rdy;
            exp_rdy = (cyc + 1 >= last_acc + last_r);
            check(in_ready == exp_rdy, "R3 ready", in_ready, exp_rdy);
            if (out_valid) begin
                if (e_pix.size() == 0) begin
                    check(1'b0, "R4 unexpected result", out_pix, -1);
                end else begin
                    check(e_cyc[0] == cyc, "R4 latency", cyc, e_cyc[0]);
                    check(out_pix == e_pix[0], req, out_pix, e_pix[0]);
                    check(out_tag == e_tag[0], "R8 tag", out_tag, e_tag[0]);
                    void'(e_pix.pop_front());
                    void'(e_tag.pop_front());
                    void'(e_cyc.pop_front());
                end
                last_pix = out_pix;
                last_tag = out_tag;
            end else begin
                check(out_pix == last_pix, "R9 pix hold", out_pix, last_pix);
                check(out_tag == (last_tag & 15), "R9 tag hold", out_tag, last_tag & 15);
                if (e_cyc.size() > 0 && e_cyc[0] <= cyc) begin
                    check(1'b0, "R4 missing result", cyc, e_cyc[0]);
                    void'(e_pix.pop_front());
                    void'(e_tag.pop_front());
                    void'(e_cyc.pop_front());
                end
            end
            acc_next = in_valid && in_ready;
            if (acc_next) begin
                int t, r, m, amt;
                longint s, v;
                for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = in_pix;
                t = clamp_t(int'(cfg_taps));
                r = (t + 2) / 3;
                s = 0;
                for (int k = 0; k < t; k++) s = s + weight(k) * hist[k];
                m = cfg_shmode;
                amt = (m == 0) ? 8 : (m == 1) ? 16 : (m == 2) ? 24 : int'(regm[15] & 63);
                v = s >>> amt;
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                e_pix.push_back(int'(v));
                e_tag.push_back(16 + int'(in_ch) * 4 + m);
                e_cyc.push_back(cyc + 1 + r + 3);
                last_acc = cyc + 1;
                last_r = r;
            end
        end
    end

    task automatic wr_reg(int k, longint val);
        @(negedge clk);
        in_valid = 1'b0;
        reg_we = 1'b1;
        reg_addr = 4'(k);
        reg_wdata = val[47:0];
        regm[k] = val & 64'hFFFF_FFFF_FFFF;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_cfg(int t, int m);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_taps = 3'(t);
        cfg_shmode = 2'(m);
    endtask

    task automatic send(int pix, int ch);
        @(negedge clk);
        in_pix = 8'(pix);
        in_ch = 2'(ch);
        in_valid = 1'b1;
        do @(posedge clk); while (!acc_next);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (e_pix.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic burst(int n, int seed);
        for (int i = 0; i < n; i++) send((i * 73 + seed * 29 + 11) % 256, (i + seed) % 4);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) regm[i] = 0;
        for (int i = 0; i < 6; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        // R1: reset values
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(out_pix == 8'd0, "R1 out_pix", out_pix, 0);
        check(out_tag == 5'd0, "R1 out_tag", out_tag, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;

        // R2: six taps, mode 0
        wr_reg(0, 40); wr_reg(1, -20); wr_reg(2, 90);
        wr_reg(3, 60); wr_reg(4, -30); wr_reg(5, 116);
        wr_reg(15, 7);
        req = "R2";
        set_cfg(6, 0);
        burst(8, 1);
        send(255, 1); send(255, 2); send(255, 3); send(255, 0);
        send(255, 1); send(255, 2);
        drain();

        // R4: three taps, one pixel per cycle
        req = "R4";
        set_cfg(3, 0);
        burst(10, 2);
        drain();

        // R5: weights above the tap count must not count
        wr_reg(4, 30000); wr_reg(5, -30000);
        req = "R5";
        set_cfg(4, 0);
        burst(6, 3);
        set_cfg(5, 0);
        burst(6, 4);
        set_cfg(2, 0);
        burst(4, 5);
        drain();

        // R6: every shifter mode on large sums
        wr_reg(0, 30000); wr_reg(1, 25000); wr_reg(2, 20000);
        wr_reg(3, 30000); wr_reg(4, 32000); wr_reg(5, 12000);
        req = "R6";
        set_cfg(6, 1);
        burst(4, 6);
        set_cfg(6, 2);
        burst(4, 7);
        set_cfg(6, 3);
        burst(4, 8);
        drain();
        wr_reg(15, 20);
        set_cfg(6, 3);
        burst(4, 9);
        drain();

        // R7: saturation at both ends
        wr_reg(0, -30000); wr_reg(1, 0);
        req = "R7";
        set_cfg(1, 0);
        send(200, 1); send(0, 2); send(77, 3);
        wr_reg(0, 32000);
        set_cfg(1, 0);
        send(200, 0); send(1, 1); send(9, 2);
        drain();

        // R10: tap count clamps
        wr_reg(0, 50); wr_reg(1, 70); wr_reg(2, -40);
        wr_reg(3, 90); wr_reg(4, 20); wr_reg(5, 100);
        req = "R10";
        set_cfg(0, 0);
        burst(5, 10);
        set_cfg(7, 0);
        burst(5, 11);
        drain();

        // R11: configuration changed while an operation is in flight
        req = "R11";
        set_cfg(6, 0);
        send(180, 1);
        set_cfg(1, 1);
        send(90, 2);
        set_cfg(6, 2);
        send(250, 3);
        set_cfg(4, 0);
        send(33, 0);
        set_cfg(0, 3);
        send(140, 1);
        drain();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule